// File: doc/BRIEF.md
# Legacy VGA Register Port Emulator

This block answers byte reads and writes to the legacy VGA I/O window (0x03C0 to 0x03DA) with a register file that behaves the way boot-time display firmware expects. No video timing or pixel path exists behind it. Values written to the attribute, sequencer, graphics and CRT controller groups are stored, and the same values come back on later reads. The DAC palette is held in an inferred RAM. The block also reproduces the side effects that firmware polls for: the attribute index/data flip-flop, the auto-incrementing palette pointers and the alternating input-status bits.

A host drives a 16-bit port address, a read or write strobe and a data byte. Read data is registered and valid one cycle after the read strobe. A 16-bit write is requested with `wr_wide`. The block splits it into two byte writes over two cycles: the low byte goes to the addressed port and the high byte goes to the next port. This makes an index-then-data pair land in order. The host leaves the cycle after a wide write idle.

Top module: `vga_port_regfile`

## Requirements
- R1: After synchronous reset, every index register, both palette pointers, the attribute flip-flop, the status register, the miscellaneous register and the DAC mask read as 0x00, and `rdata` is 0x00.
- R2: Port 0x03C0 acts as the attribute index while the attribute flip-flop is 0 and as attribute data at the current index while it is 1. Every read or write of 0x03C0 toggles the flip-flop. Data at an index at or above the attribute size reads 0xFF, and writes to such an index are dropped.
- R3: A read of 0x03C1 returns the attribute data at the current index, or 0xFF when the index is out of range, and leaves the flip-flop unchanged.
- R4: A read of 0x03DA clears the attribute flip-flop and returns the status byte. The status byte is then inverted in bits 0 and 3 (XOR 0x09), so successive reads alternate between two values.
- R5: A write of byte v to 0x03C7 sets the palette read pointer to 3*v, and a write of v to 0x03C8 sets the palette write pointer to 3*v. Reads of 0x03C7 and 0x03C8 return the low 8 bits of the current pointer.
- R6: A write to 0x03C9 stores at the write pointer and increments it. A read of 0x03C9 returns the entry at the read pointer and increments it. Once a pointer has reached the palette size, reads give 0xFF, writes are dropped and that pointer no longer moves.
- R7: A write to 0x03C2 sets the miscellaneous register, which reads back at 0x03CC. The DAC mask is written and read at 0x03C6.
- R8: While bit 0 of the miscellaneous register is 0, writes to 0x03D4 and 0x03D5 are ignored and reads of both return 0xFF.
- R9: The sequencer (0x03C4/0x03C5), graphics (0x03CE/0x03CF) and CRT (0x03D4/0x03D5) pairs each read back their index unchanged. Each data port reads or writes the entry at that index only when the index is below the group's size; otherwise the read gives 0xFF and the write is dropped.
- R10: A read of any port without a readable register returns 0xFF. This covers 0x03C2, 0x03C3, 0x03CA, 0x03D0 and addresses outside the window.
- R11: With `wr_en` and `wr_wide` high, `wdata` is written to `addr` in that cycle and `wdata_hi` to `addr`+1 in the next cycle.
- R12: `rdata` shows the value of a read in the cycle after `rd_en` and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | I/O port address |
| wr_en | input | 1 | Write strobe |
| wr_wide | input | 1 | With `wr_en`: 16-bit write of `wdata_hi`:`wdata` |
| rd_en | input | 1 | Read strobe; read side effects occur once per cycle it is high |
| wdata | input | 8 | Write byte (low byte of a wide write) |
| wdata_hi | input | 8 | High byte of a wide write |
| rdata | output | 8 | Registered read data, valid the cycle after `rd_en` |

## Verification
The assertions assume two things about the host: it never raises `rd_en` and `wr_en` in the same cycle, and it keeps both strobes low in the cycle after a wide write, which is when the block applies the high byte. Two of the checker's properties state these assumptions as input rules, and the other properties rely on them. The stimulus meets both rules by construction. Every bench task drives one access and returns the strobes low, and the wide-write task waits one idle cycle before it returns. The randomized phase is built only from these tasks, so the rules hold there as well.

// File: rtl/vga_emu_pkg.sv
package vga_emu_pkg;

  localparam int ADDR_W = 16;
  localparam int DATA_W = 8;

  localparam logic [ADDR_W-1:0] PORT_ATTR     = 16'h03C0;
  localparam logic [ADDR_W-1:0] PORT_ATTR_RD  = 16'h03C1;
  localparam logic [ADDR_W-1:0] PORT_MISC_WR  = 16'h03C2;
  localparam logic [ADDR_W-1:0] PORT_DAC_MASK = 16'h03C6;
  localparam logic [ADDR_W-1:0] PORT_DAC_RIDX = 16'h03C7;
  localparam logic [ADDR_W-1:0] PORT_DAC_WIDX = 16'h03C8;
  localparam logic [ADDR_W-1:0] PORT_DAC_DATA = 16'h03C9;
  localparam logic [ADDR_W-1:0] PORT_MISC_RD  = 16'h03CC;
  localparam logic [ADDR_W-1:0] PORT_STATUS   = 16'h03DA;

  // index/data pairs: data port sits at index port + 1
  localparam int NUM_BANKS = 3;
  localparam logic [ADDR_W-1:0] BANK_IDX_PORT [NUM_BANKS] =
    '{16'h03C4, 16'h03CE, 16'h03D4};
  // which pairs are gated by bit 0 of the miscellaneous register
  localparam logic [NUM_BANKS-1:0] BANK_GATED = 3'b100;

  localparam logic [DATA_W-1:0] NO_REG_BYTE = 8'hFF;
  localparam logic [DATA_W-1:0] STATUS_FLIP = 8'h09;

  typedef enum logic {
    RSRC_REG = 1'b0,
    RSRC_PAL = 1'b1
  } rd_src_e;

endpackage

// File: rtl/vga_wide_split.sv
module vga_wide_split
  import vga_emu_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  input  logic [DATA_W-1:0] wdata_hi,
  output logic [ADDR_W-1:0] acc_addr,
  output logic              acc_wr,
  output logic              acc_rd,
  output logic [DATA_W-1:0] acc_wdata
);

  logic              pend_q;
  logic [ADDR_W-1:0] pend_addr_q;
  logic [DATA_W-1:0] pend_data_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= 1'b0;
      pend_addr_q <= '0;
      pend_data_q <= '0;
    end else begin
      pend_q <= wr_en && wr_wide && !pend_q;
      if (wr_en && wr_wide && !pend_q) begin
        pend_addr_q <= addr + ADDR_W'(1);
        pend_data_q <= wdata_hi;
      end
    end
  end

  // the second half of a wide write owns the cycle after it
  assign acc_addr  = pend_q ? pend_addr_q : addr;
  assign acc_wr    = pend_q || wr_en;
  assign acc_rd    = !pend_q && rd_en;
  assign acc_wdata = pend_q ? pend_data_q : wdata;

endmodule

// File: rtl/vga_idx_bank.sv
module vga_idx_bank
  import vga_emu_pkg::*;
#(
  parameter int DEPTH = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              idx_we,
  input  logic              dat_we,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] idx_q,
  output logic [DATA_W-1:0] dat_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              in_rng;

  assign in_rng = int'(idx_q) < DEPTH;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q <= '0;
    end else if (en && idx_we) begin
      idx_q <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (en && dat_we && in_rng) begin
      mem[idx_q[AW-1:0]] <= wdata;
    end
  end

  assign dat_o = (en && in_rng) ? mem[idx_q[AW-1:0]] : NO_REG_BYTE;

endmodule

// File: rtl/vga_attr_ctl.sv
module vga_attr_ctl
  import vga_emu_pkg::*;
#(
  parameter int DEPTH = 21
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              port_wr,
  input  logic              port_rd,
  input  logic              ff_clr,
  input  logic [DATA_W-1:0] wdata,
  output logic              ff_q,
  output logic [DATA_W-1:0] idx_q,
  output logic [DATA_W-1:0] dat_o
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] mem [DEPTH];
  logic              in_rng;

  assign in_rng = int'(idx_q) < DEPTH;

  always_ff @(posedge clk) begin
    if (rst) begin
      ff_q  <= 1'b0;
      idx_q <= '0;
    end else begin
      if (ff_clr) begin
        ff_q <= 1'b0;
      end else if (port_wr || port_rd) begin
        ff_q <= !ff_q;
      end
      if (port_wr && !ff_q) begin
        idx_q <= wdata;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (port_wr && ff_q && in_rng) begin
      mem[idx_q[AW-1:0]] <= wdata;
    end
  end

  assign dat_o = in_rng ? mem[idx_q[AW-1:0]] : NO_REG_BYTE;

endmodule

// File: rtl/vga_dac_palette.sv
module vga_dac_palette
  import vga_emu_pkg::*;
#(
  parameter int DEPTH = 768,
  parameter int PTR_W = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_load,
  input  logic              wr_load,
  input  logic              dat_wr,
  input  logic              dat_rd,
  input  logic [DATA_W-1:0] wdata,
  output logic [PTR_W-1:0]  rptr_q,
  output logic [PTR_W-1:0]  wptr_q,
  output logic [DATA_W-1:0] rd_byte
);

  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DATA_W-1:0] pal [DEPTH];
  logic [DATA_W-1:0] ram_q;
  logic              hit_q;
  logic [PTR_W-1:0]  load_val;
  logic              r_ok;
  logic              w_ok;

  // three entries per colour: pointer = 2v + v
  assign load_val = PTR_W'({wdata, 1'b0}) + PTR_W'(wdata);
  assign r_ok     = rptr_q < PTR_W'(DEPTH);
  assign w_ok     = wptr_q < PTR_W'(DEPTH);

  always_ff @(posedge clk) begin
    if (rst) begin
      rptr_q <= '0;
      wptr_q <= '0;
      hit_q  <= 1'b0;
    end else begin
      if (rd_load) begin
        rptr_q <= load_val;
      end else if (dat_rd && r_ok) begin
        rptr_q <= rptr_q + PTR_W'(1);
      end
      if (wr_load) begin
        wptr_q <= load_val;
      end else if (dat_wr && w_ok) begin
        wptr_q <= wptr_q + PTR_W'(1);
      end
      if (dat_rd) begin
        hit_q <= r_ok;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (dat_wr && w_ok) begin
      pal[wptr_q[AW-1:0]] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (dat_rd && r_ok) begin
      ram_q <= pal[rptr_q[AW-1:0]];
    end
  end

  assign rd_byte = hit_q ? ram_q : NO_REG_BYTE;

endmodule

// File: rtl/vga_port_regfile.sv
module vga_port_regfile
  import vga_emu_pkg::*;
#(
  parameter int ATTR_N = 21,
  parameter int SEQ_N  = 5,
  parameter int GFX_N  = 9,
  parameter int CRT_N  = 25,
  parameter int PAL_N  = 768
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [15:0] addr,
  input  logic        wr_en,
  input  logic        wr_wide,
  input  logic        rd_en,
  input  logic [7:0]  wdata,
  input  logic [7:0]  wdata_hi,
  output logic [7:0]  rdata
);

  localparam int PAL_AW = (PAL_N > 1) ? $clog2(PAL_N) : 1;
  localparam int PTR_W  = (PAL_AW + 1 > 10) ? PAL_AW + 1 : 10;

  logic [ADDR_W-1:0] acc_addr;
  logic              acc_wr;
  logic              acc_rd;
  logic [DATA_W-1:0] acc_wdata;

  logic [DATA_W-1:0] misc_q;
  logic [DATA_W-1:0] mask_q;
  logic [DATA_W-1:0] status_q;

  logic              attr_ff;
  logic [DATA_W-1:0] attr_idx;
  logic [DATA_W-1:0] attr_dat;

  logic [PTR_W-1:0]  dac_rptr;
  logic [PTR_W-1:0]  dac_wptr;
  logic [DATA_W-1:0] dac_rd;

  logic [DATA_W-1:0] bank_idx [NUM_BANKS];
  logic [DATA_W-1:0] bank_dat [NUM_BANKS];
  logic [NUM_BANKS-1:0] bank_en;

  logic [DATA_W-1:0] rd_val;
  logic [DATA_W-1:0] rdata_q;
  rd_src_e           rsrc_q;
  logic              status_rd;

  vga_wide_split u_split (
    .clk       (clk),
    .rst       (rst),
    .addr      (addr),
    .wr_en     (wr_en),
    .wr_wide   (wr_wide),
    .rd_en     (rd_en),
    .wdata     (wdata),
    .wdata_hi  (wdata_hi),
    .acc_addr  (acc_addr),
    .acc_wr    (acc_wr),
    .acc_rd    (acc_rd),
    .acc_wdata (acc_wdata)
  );

  assign status_rd = acc_rd && (acc_addr == PORT_STATUS);

  vga_attr_ctl #(.DEPTH(ATTR_N)) u_attr (
    .clk     (clk),
    .rst     (rst),
    .port_wr (acc_wr && (acc_addr == PORT_ATTR)),
    .port_rd (acc_rd && (acc_addr == PORT_ATTR)),
    .ff_clr  (status_rd),
    .wdata   (acc_wdata),
    .ff_q    (attr_ff),
    .idx_q   (attr_idx),
    .dat_o   (attr_dat)
  );

  vga_dac_palette #(.DEPTH(PAL_N), .PTR_W(PTR_W)) u_dac (
    .clk     (clk),
    .rst     (rst),
    .rd_load (acc_wr && (acc_addr == PORT_DAC_RIDX)),
    .wr_load (acc_wr && (acc_addr == PORT_DAC_WIDX)),
    .dat_wr  (acc_wr && (acc_addr == PORT_DAC_DATA)),
    .dat_rd  (acc_rd && (acc_addr == PORT_DAC_DATA)),
    .wdata   (acc_wdata),
    .rptr_q  (dac_rptr),
    .wptr_q  (dac_wptr),
    .rd_byte (dac_rd)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    localparam int D = (b == 0) ? SEQ_N : (b == 1) ? GFX_N : CRT_N;
    assign bank_en[b] = BANK_GATED[b] ? misc_q[0] : 1'b1;

    vga_idx_bank #(.DEPTH(D)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .en     (bank_en[b]),
      .idx_we (acc_wr && (acc_addr == BANK_IDX_PORT[b])),
      .dat_we (acc_wr && (acc_addr == BANK_IDX_PORT[b] + ADDR_W'(1))),
      .wdata  (acc_wdata),
      .idx_q  (bank_idx[b]),
      .dat_o  (bank_dat[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      misc_q   <= '0;
      mask_q   <= '0;
      status_q <= '0;
    end else begin
      if (acc_wr && (acc_addr == PORT_MISC_WR)) begin
        misc_q <= acc_wdata;
      end
      if (acc_wr && (acc_addr == PORT_DAC_MASK)) begin
        mask_q <= acc_wdata;
      end
      if (status_rd) begin
        status_q <= status_q ^ STATUS_FLIP;
      end
    end
  end

  always_comb begin
    rd_val = NO_REG_BYTE;
    case (acc_addr)
      PORT_ATTR:     rd_val = attr_ff ? attr_dat : attr_idx;
      PORT_ATTR_RD:  rd_val = attr_dat;
      PORT_DAC_MASK: rd_val = mask_q;
      PORT_DAC_RIDX: rd_val = dac_rptr[7:0];
      PORT_DAC_WIDX: rd_val = dac_wptr[7:0];
      PORT_MISC_RD:  rd_val = misc_q;
      PORT_STATUS:   rd_val = status_q;
      default:       rd_val = NO_REG_BYTE;
    endcase
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (acc_addr == BANK_IDX_PORT[b]) begin
        rd_val = bank_en[b] ? bank_idx[b] : NO_REG_BYTE;
      end
      if (acc_addr == BANK_IDX_PORT[b] + ADDR_W'(1)) begin
        rd_val = bank_dat[b];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
      rsrc_q  <= RSRC_REG;
    end else if (acc_rd) begin
      rdata_q <= rd_val;
      rsrc_q  <= (acc_addr == PORT_DAC_DATA) ? RSRC_PAL : RSRC_REG;
    end
  end

  assign rdata = (rsrc_q == RSRC_PAL) ? dac_rd : rdata_q;

endmodule

// File: rtl/vga_port_regfile_chk.sv
module vga_port_regfile_chk
  import vga_emu_pkg::*;
#(
  parameter int PTR_W = 10,
  parameter int PAL_N = 768
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              wr_wide,
  input logic              rd_en,
  input logic [ADDR_W-1:0] acc_addr,
  input logic              acc_wr,
  input logic              acc_rd,
  input logic              attr_ff,
  input logic [DATA_W-1:0] status_q,
  input logic [DATA_W-1:0] misc_q,
  input logic [DATA_W-1:0] crt_idx,
  input logic [PTR_W-1:0]  rptr,
  input logic [PTR_W-1:0]  wptr,
  input logic [DATA_W-1:0] rdata
);

  // input rules the other properties rely on (R11)
  a_r11_no_overlap: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && rd_en));

  a_r11_idle_after_wide: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_wide) |=> (!wr_en && !rd_en));

  a_r11_second_half: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_wide) |=> (acc_wr && (acc_addr == $past(addr) + ADDR_W'(1))));

  a_r2_ff_toggle: assert property (@(posedge clk) disable iff (rst)
    ((acc_wr || acc_rd) && (acc_addr == PORT_ATTR)) |=> (attr_ff != $past(attr_ff)));

  a_r4_ff_clear: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && (acc_addr == PORT_STATUS)) |=> !attr_ff);

  a_r4_status_flip: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && (acc_addr == PORT_STATUS)) |=> (status_q == ($past(status_q) ^ STATUS_FLIP)));

  a_r4_status_hold: assert property (@(posedge clk) disable iff (rst)
    !(acc_rd && (acc_addr == PORT_STATUS)) |=> $stable(status_q));

  a_r8_crt_gate: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && (acc_addr == 16'h03D4) && !misc_q[0]) |=> $stable(crt_idx));

  a_r6_wptr_step: assert property (@(posedge clk) disable iff (rst)
    (acc_wr && (acc_addr == PORT_DAC_DATA) && (wptr < PTR_W'(PAL_N)))
      |=> (wptr == $past(wptr) + PTR_W'(1)));

  a_r6_rptr_stop: assert property (@(posedge clk) disable iff (rst)
    (acc_rd && (acc_addr == PORT_DAC_DATA) && (rptr >= PTR_W'(PAL_N)))
      |=> $stable(rptr));

  a_r12_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !acc_rd |=> $stable(rdata));

endmodule

bind vga_port_regfile vga_port_regfile_chk #(.PTR_W(PTR_W), .PAL_N(PAL_N)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .addr     (addr),
  .wr_en    (wr_en),
  .wr_wide  (wr_wide),
  .rd_en    (rd_en),
  .acc_addr (acc_addr),
  .acc_wr   (acc_wr),
  .acc_rd   (acc_rd),
  .attr_ff  (attr_ff),
  .status_q (status_q),
  .misc_q   (misc_q),
  .crt_idx  (bank_idx[2]),
  .rptr     (dac_rptr),
  .wptr     (dac_wptr),
  .rdata    (rdata)
);

// File: tb/vga_port_regfile_bench.sv
`timescale 1ns/1ps
module vga_port_regfile_bench;

  localparam int ATTR_N = 21;
  localparam int SEQ_N  = 5;
  localparam int GFX_N  = 9;
  localparam int CRT_N  = 25;
  localparam int PAL_N  = 768;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic        wr_en = 1'b0;
  logic        wr_wide = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  wdata = '0;
  logic [7:0]  wdata_hi = '0;
  logic [7:0]  rdata;

  always #4 clk = ~clk;

  vga_port_regfile u_vga_port_regfile (
    .clk      (clk),
    .rst      (rst),
    .addr     (addr),
    .wr_en    (wr_en),
    .wr_wide  (wr_wide),
    .rd_en    (rd_en),
    .wdata    (wdata),
    .wdata_hi (wdata_hi),
    .rdata    (rdata)
  );

  // behavioural reference state
  logic [7:0] m_attr [ATTR_N];
  logic [7:0] m_seq [SEQ_N];
  logic [7:0] m_gfx [GFX_N];
  logic [7:0] m_crt [CRT_N];
  logic [7:0] m_pal [PAL_N];
  int         m_aidx, m_sidx, m_gidx, m_cidx, m_rptr, m_wptr;
  bit         m_ff;
  logic [7:0] m_misc, m_mask, m_status;
  logic [7:0] exp_rdata = 8'h00;

  int    checks = 0;
  int    errors = 0;
  bit    chk_on = 1'b0;
  bit    done = 1'b0;
  string cur_req = "R1";

  function automatic void m_write(int p, logic [7:0] d);
    case (p)
      'h3C0: begin
        if (!m_ff) m_aidx = int'(d);
        else if (m_aidx < ATTR_N) m_attr[m_aidx] = d;
        m_ff = !m_ff;
      end
      'h3C2: m_misc = d;
      'h3C4: m_sidx = int'(d);
      'h3C5: if (m_sidx < SEQ_N) m_seq[m_sidx] = d;
      'h3C6: m_mask = d;
      'h3C7: m_rptr = 3 * int'(d);
      'h3C8: m_wptr = 3 * int'(d);
      'h3C9: if (m_wptr < PAL_N) begin m_pal[m_wptr] = d; m_wptr++; end
      'h3CE: m_gidx = int'(d);
      'h3CF: if (m_gidx < GFX_N) m_gfx[m_gidx] = d;
      'h3D4: if (m_misc[0]) m_cidx = int'(d);
      'h3D5: if (m_misc[0] && m_cidx < CRT_N) m_crt[m_cidx] = d;
      default: ;
    endcase
  endfunction

  function automatic logic [7:0] m_read(int p);
    logic [7:0] v = 8'hFF;
    case (p)
      'h3C0: begin
        if (!m_ff) v = 8'(m_aidx);
        else if (m_aidx < ATTR_N) v = m_attr[m_aidx];
        m_ff = !m_ff;
      end
      'h3C1: if (m_aidx < ATTR_N) v = m_attr[m_aidx];
      'h3C4: v = 8'(m_sidx);
      'h3C5: if (m_sidx < SEQ_N) v = m_seq[m_sidx];
      'h3C6: v = m_mask;
      'h3C7: v = 8'(m_rptr);
      'h3C8: v = 8'(m_wptr);
      'h3C9: if (m_rptr < PAL_N) begin v = m_pal[m_rptr]; m_rptr++; end
      'h3CC: v = m_misc;
      'h3CE: v = 8'(m_gidx);
      'h3CF: if (m_gidx < GFX_N) v = m_gfx[m_gidx];
      'h3D4: if (m_misc[0]) v = 8'(m_cidx);
      'h3D5: if (m_misc[0] && m_cidx < CRT_N) v = m_crt[m_cidx];
      'h3DA: begin m_ff = 1'b0; v = m_status; m_status = m_status ^ 8'h09; end
      default: ;
    endcase
    return v;
  endfunction

  // compare every clock, away from the active edge
  always @(negedge clk) begin
    if (chk_on && !done) begin
      checks++;
      if (rdata !== exp_rdata) begin
        errors++;
        $display("FAIL %s rdata actual %02h expected %02h", cur_req, rdata, exp_rdata);
      end
    end
  end

  task automatic do_wr(int p, logic [7:0] d);
    addr = 16'(p); wdata = d; wr_en = 1'b1;
    m_write(p, d);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_ww(int p, logic [15:0] d);
    addr = 16'(p); wdata = d[7:0]; wdata_hi = d[15:8];
    wr_en = 1'b1; wr_wide = 1'b1;
    m_write(p, d[7:0]);
    m_write(p + 1, d[15:8]);
    @(negedge clk);
    wr_en = 1'b0; wr_wide = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_rd(int p);
    logic [7:0] v;
    addr = 16'(p); rd_en = 1'b1;
    v = m_read(p);
    @(posedge clk);
    exp_rdata = v;
    @(negedge clk);
    rd_en = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int ports [18] = '{'h3C0, 'h3C1, 'h3C2, 'h3C3, 'h3C4, 'h3C5, 'h3C6, 'h3C7, 'h3C8,
                       'h3C9, 'h3CC, 'h3CE, 'h3CF, 'h3D4, 'h3D5, 'h3DA, 'h3D0, 'h100};
    m_aidx = 0; m_sidx = 0; m_gidx = 0; m_cidx = 0; m_rptr = 0; m_wptr = 0;
    m_ff = 1'b0; m_misc = '0; m_mask = '0; m_status = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    chk_on = 1'b1;

    // R1: reset values
    cur_req = "R1";
    idle(2);
    do_rd('h3C0); do_rd('h3DA); do_rd('h3C7); do_rd('h3C8);
    do_rd('h3CC); do_rd('h3C6); do_rd('h3C4); do_rd('h3CE);

    // R7: misc and mask
    cur_req = "R7";
    do_wr('h3C2, 8'h67); do_rd('h3CC);
    do_wr('h3C6, 8'hA3); do_rd('h3C6);

    // fill arrays so every later read is defined
    cur_req = "R9";
    do_rd('h3DA);
    for (int i = 0; i < ATTR_N; i++) begin
      do_wr('h3C0, 8'(i)); do_wr('h3C0, 8'($urandom));
    end
    for (int i = 0; i < SEQ_N; i++) do_ww('h3C4, {8'($urandom), 8'(i)});
    for (int i = 0; i < GFX_N; i++) do_ww('h3CE, {8'($urandom), 8'(i)});
    for (int i = 0; i < CRT_N; i++) do_ww('h3D4, {8'($urandom), 8'(i)});
    do_wr('h3C8, 8'h00);
    for (int i = 0; i < PAL_N; i++) do_wr('h3C9, 8'($urandom));

    // R2: shared index/data port
    cur_req = "R2";
    do_rd('h3DA);
    do_wr('h3C0, 8'd5); do_wr('h3C0, 8'hA5);
    do_rd('h3C0); do_rd('h3C0); do_rd('h3C0); do_rd('h3C0);
    do_wr('h3C0, 8'd30); do_wr('h3C0, 8'h11);
    do_rd('h3C0); do_rd('h3C0);

    // R3: data read without toggling
    cur_req = "R3";
    do_rd('h3C1);
    do_wr('h3C0, 8'd20); do_rd('h3C1); do_rd('h3C1); do_rd('h3C0);

    // R4: status alternation clears the flip-flop
    cur_req = "R4";
    do_wr('h3C0, 8'd3);
    do_rd('h3DA); do_rd('h3DA); do_rd('h3DA);
    do_wr('h3C0, 8'd7); do_rd('h3C0); do_rd('h3DA); do_rd('h3C0);

    // R5: pointer load and readback
    cur_req = "R5";
    do_wr('h3C8, 8'd2); do_rd('h3C8);
    do_wr('h3C7, 8'd100); do_rd('h3C7);

    // R6: palette access and bound
    cur_req = "R6";
    do_wr('h3C9, 8'h11); do_wr('h3C9, 8'h22); do_wr('h3C9, 8'h33);
    do_wr('h3C7, 8'd2);
    do_rd('h3C9); do_rd('h3C9); do_rd('h3C9); do_rd('h3C7);
    do_wr('h3C8, 8'd255);
    do_wr('h3C9, 8'h44); do_wr('h3C9, 8'h55); do_wr('h3C9, 8'h66); do_wr('h3C9, 8'h77);
    do_rd('h3C8);
    do_wr('h3C7, 8'd255);
    do_rd('h3C9); do_rd('h3C9); do_rd('h3C9); do_rd('h3C9); do_rd('h3C9); do_rd('h3C7);

    // R8: CRT gate
    cur_req = "R8";
    do_wr('h3D4, 8'd4); do_wr('h3D5, 8'h5A); do_rd('h3D5);
    do_wr('h3C2, 8'h66);
    do_wr('h3D4, 8'd9); do_wr('h3D5, 8'h99);
    do_rd('h3D4); do_rd('h3D5);
    do_wr('h3C2, 8'h67);
    do_rd('h3D4); do_rd('h3D5);

    // R9: index/data pairs and range limits
    cur_req = "R9";
    do_wr('h3C4, 8'd3); do_wr('h3C5, 8'hC3); do_rd('h3C4); do_rd('h3C5);
    do_wr('h3C4, 8'd7); do_wr('h3C5, 8'h01); do_rd('h3C5); do_rd('h3C4);
    do_wr('h3CE, 8'd8); do_wr('h3CF, 8'hE8); do_rd('h3CF);
    do_wr('h3CE, 8'd9); do_rd('h3CF);
    do_wr('h3D4, 8'd25); do_wr('h3D5, 8'h12); do_rd('h3D5);

    // R10: no readable register
    cur_req = "R10";
    do_rd('h3C2); do_rd('h3C3); do_rd('h3CA); do_rd('h3D0);
    do_rd('h0100); do_rd('h3DB);

    // R11: 16-bit writes split low then high
    cur_req = "R11";
    do_ww('h3C4, 16'h9C02); do_rd('h3C4); do_rd('h3C5);
    do_ww('h3D4, 16'h4E11); do_rd('h3D4); do_rd('h3D5);
    do_rd('h3DA);
    do_ww('h3C0, 16'hFF06); do_rd('h3C0);
    do_ww('h3C8, 16'hB710); do_rd('h3C8);

    // R12: rdata holds between reads
    cur_req = "R12";
    do_rd('h3C6);
    do_wr('h3C6, 8'h5C);
    idle(5);
    do_rd('h3C9);
    do_wr('h3C7, 8'd0);
    idle(3);

    // mixed traffic
    cur_req = "R9";
    for (int n = 0; n < 400; n++) begin
      int p  = ports[$urandom % 18];
      int op = int'($urandom % 5);
      if (op < 2)      do_wr(p, 8'($urandom));
      else if (op < 4) do_rd(p);
      else             do_ww(p, 16'($urandom));
    end
    idle(2);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule